// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Block

This block collects up to 32 interrupt sources into one cause register and gates them with a mask register. Software reaches it over a simple single-cycle register bus. The block drives one interrupt line, which is high whenever any cause bit is set and not masked. A given source owns the same bit index in every register of the block.

Software decides, bit by bit, how a pending cause is acknowledged:

- **Write-one-to-clear:** writing a one to the bit clears it.
- **Clear-on-read:** a read clears the bit and returns its value from before the clear.

Software can also raise causes from the bus. It can set or clear mask bits atomically, without a read-modify-write. A masked view of the causes is available, and it acknowledges with the same per-bit rule as the cause register.

Hardware events arrive as a 32-bit vector, and a high bit sets its cause. When an event and a clear hit the same bit in the same cycle, the event wins, so no event is lost.

Top module: `irq_cause_regs`

## Requirements
- R1: After reset the cause register is all zeros, the mask is all ones, the clear-mode control is all zeros, `irq_out` is low and `bus_rdata` is zero.
- R2: Register word indices on `bus_addr` are: 0 clear-mode control, 1 cause, 2 masked cause, 3 cause set, 4 mask value, 5 mask set, 6 mask clear. Index 7 reads zero, and writes to index 7 change nothing.
- R3: A high bit of `hw_event` sets the matching cause bit at the next clock edge. This holds even if the same cycle clears that bit.
- R4: For a bit whose clear-mode control bit is 0, writing a 1 to that bit of the cause or masked-cause register clears the cause bit. Writing a 0 leaves it unchanged.
- R5: For a bit whose clear-mode control bit is 1, a read of the cause register clears the bit. A read of the masked-cause register clears it only if the bit is unmasked. The read returns the value before the clear, and a write to the cause or masked-cause register does not clear the bit.
- R6: A read of the masked-cause register returns cause AND NOT mask.
- R7: Writing a 1 to a bit of the cause-set register sets that cause bit.
- R8: The mask value register is readable and directly writable. Writing a 1 to a mask-set bit sets that mask bit, writing a 1 to a mask-clear bit clears it, and a 0 written to either leaves the bit unchanged.
- R9: Reads of the cause-set, mask-set and mask-clear registers return zero.
- R10: `irq_out` is the OR of cause AND NOT mask, following the register state with no extra delay.
- R11: A read accepted at a clock edge presents its data on `bus_rdata` with `bus_rvalid` high in the following cycle. `bus_rdata` holds its value until the next read.
- R12: The clear-mode control register reads back the value last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read |
| hw_event | input | 32 | Hardware event pulses, one per source |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A corrupted cause bit shows up on `irq_out` in the same cycle whenever that bit is unmasked. A read of the cause or masked-cause register then exposes it one cycle later on `bus_rdata`.

A wrong mask bit is visible two ways. The mask readback shows it directly, and the masked view misreports the next unmasked event.

A wrong acknowledge rule leaves a bit set, or wrongly clear, on the very next read. A lost hardware event under a simultaneous clear therefore appears no later than the read that follows.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;

  localparam int REG_IDX_W = 3;

  typedef enum logic [REG_IDX_W-1:0] {
    IDX_MODE   = 3'd0,
    IDX_CAUSE  = 3'd1,
    IDX_MCAUSE = 3'd2,
    IDX_CSET   = 3'd3,
    IDX_MASK   = 3'd4,
    IDX_MSET   = 3'd5,
    IDX_MCLR   = 3'd6,
    IDX_RSVD   = 3'd7
  } reg_idx_e;

  typedef struct packed {
    logic wr_mode;
    logic wr_cause;
    logic wr_mcause;
    logic wr_cset;
    logic wr_mask;
    logic wr_mset;
    logic wr_mclr;
    logic rd_cause;
    logic rd_mcause;
    logic rd_any;
  } strobe_t;

endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
  import irq_cause_pkg::*;
(
  input  logic                 en,
  input  logic                 we,
  input  logic [REG_IDX_W-1:0] addr,
  output strobe_t              stb
);

  reg_idx_e idx;

  always_comb begin
    idx = reg_idx_e'(addr);
    stb = '0;
    if (en) begin
      stb.rd_any = !we;
      unique case (idx)
        IDX_MODE:   stb.wr_mode   = we;
        IDX_CAUSE:  begin
          stb.wr_cause = we;
          stb.rd_cause = !we;
        end
        IDX_MCAUSE: begin
          stb.wr_mcause = we;
          stb.rd_mcause = !we;
        end
        IDX_CSET:   stb.wr_cset   = we;
        IDX_MASK:   stb.wr_mask   = we;
        IDX_MSET:   stb.wr_mset   = we;
        IDX_MCLR:   stb.wr_mclr   = we;
        default:    ;
      endcase
    end
  end

endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
  import irq_cause_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  strobe_t      stb,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mode_q,
  output logic [W-1:0] mask_q
);

  logic [W-1:0] mode_d, mask_d;
  logic         mode_en, mask_en;

  always_comb begin
    mode_en = stb.wr_mode;
    mode_d  = wdata;
  end

  // Mask next state: one bit slice per source.
  for (genvar i = 0; i < W; i++) begin : g_mask
    always_comb begin
      mask_d[i] = mask_q[i];
      if (stb.wr_mask)      mask_d[i] = wdata[i];
      else if (stb.wr_mset) mask_d[i] = mask_q[i] | wdata[i];
      else if (stb.wr_mclr) mask_d[i] = mask_q[i] & ~wdata[i];
    end
  end

  always_comb mask_en = stb.wr_mask | stb.wr_mset | stb.wr_mclr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      mask_q <= '1;
    end else begin
      if (mode_en) mode_q <= mode_d;
      if (mask_en) mask_q <= mask_d;
    end
  end

endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank
  import irq_cause_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  strobe_t      stb,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hw_event,
  input  logic [W-1:0] mode,
  input  logic [W-1:0] mask,
  output logic [W-1:0] cause_q
);

  logic [W-1:0] set_v, clr_v, cause_d;
  logic         cause_en;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic w1c_hit, cor_hit;
    always_comb begin
      // write-one-to-clear path, only for bits in W1C mode
      w1c_hit  = (stb.wr_cause | stb.wr_mcause) & wdata[i] & ~mode[i];
      // clear-on-read path, masked view clears only unmasked bits
      cor_hit  = mode[i] & (stb.rd_cause | (stb.rd_mcause & ~mask[i]));
      clr_v[i] = w1c_hit | cor_hit;
      set_v[i] = hw_event[i] | (stb.wr_cset & wdata[i]);
      // set has priority over clear
      cause_d[i] = (cause_q[i] & ~clr_v[i]) | set_v[i];
    end
  end

  always_comb cause_en = (|set_v) | (|clr_v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else if (cause_en) cause_q <= cause_d;
  end

endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux
  import irq_cause_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  strobe_t              stb,
  input  logic [REG_IDX_W-1:0] addr,
  input  logic [W-1:0]         mode,
  input  logic [W-1:0]         cause,
  input  logic [W-1:0]         mask,
  output logic [W-1:0]         rdata,
  output logic                 rvalid
);

  logic [W-1:0] rdata_d;
  reg_idx_e     idx;

  always_comb begin
    idx = reg_idx_e'(addr);
    unique case (idx)
      IDX_MODE:   rdata_d = mode;
      IDX_CAUSE:  rdata_d = cause;
      IDX_MCAUSE: rdata_d = cause & ~mask;
      IDX_MASK:   rdata_d = mask;
      default:    rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= stb.rd_any;
      if (stb.rd_any) rdata <= rdata_d;
    end
  end

endmodule

// File: rtl/irq_cause_regs.sv
module irq_cause_regs
  import irq_cause_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_en,
  input  logic                 bus_we,
  input  logic [REG_IDX_W-1:0] bus_addr,
  input  logic [W-1:0]         bus_wdata,
  output logic [W-1:0]         bus_rdata,
  output logic                 bus_rvalid,
  input  logic [W-1:0]         hw_event,
  output logic                 irq_out
);

  strobe_t      stb;
  logic [W-1:0] mode_q, mask_q, cause_q;

  irq_addr_dec u_dec (
    .en   (bus_en),
    .we   (bus_we),
    .addr (bus_addr),
    .stb  (stb)
  );

  irq_ctl_regs #(.W(W)) u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb    (stb),
    .wdata  (bus_wdata),
    .mode_q (mode_q),
    .mask_q (mask_q)
  );

  irq_cause_bank #(.W(W)) u_cause (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .wdata    (bus_wdata),
    .hw_event (hw_event),
    .mode     (mode_q),
    .mask     (mask_q),
    .cause_q  (cause_q)
  );

  irq_rd_mux #(.W(W)) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb    (stb),
    .addr   (bus_addr),
    .mode   (mode_q),
    .cause  (cause_q),
    .mask   (mask_q),
    .rdata  (bus_rdata),
    .rvalid (bus_rvalid)
  );

  always_comb irq_out = |(cause_q & ~mask_q);

endmodule

// File: rtl/irq_cause_regs_chk.sv
module irq_cause_regs_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_en,
  input logic         bus_we,
  input logic [2:0]   bus_addr,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] bus_rdata,
  input logic         bus_rvalid,
  input logic [W-1:0] hw_event,
  input logic [W-1:0] cause,
  input logic [W-1:0] mask,
  input logic [W-1:0] mode
);

  // R3
  hw_event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_event != '0) |=> ((cause & $past(hw_event)) == $past(hw_event)));

  // R11
  read_cause_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr == 3'd1) |=> (bus_rvalid && bus_rdata == $past(cause)));

  // R5
  cor_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr == 3'd1 && hw_event == '0) |=> ((cause & $past(mode)) == '0));

  // R8
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == 3'd5) |=> ((mask & $past(bus_wdata)) == $past(bus_wdata)));

  // R8
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == 3'd6) |=> ((mask & $past(bus_wdata)) == '0));

  // R9
  wo_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && (bus_addr == 3'd3 || bus_addr == 3'd5 || bus_addr == 3'd6))
      |=> (bus_rdata == '0));

  // R2
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_en && hw_event == '0) |=> ($stable(cause) && $stable(mask) && $stable(mode)));

endmodule

bind irq_cause_regs irq_cause_regs_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_en     (bus_en),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .hw_event   (hw_event),
  .cause      (cause_q),
  .mask       (mask_q),
  .mode       (mode_q)
);

// File: tb/sim_irq_cause_regs.sv
`timescale 1ns/1ps
module sim_irq_cause_regs;

  localparam int W = 32;

  logic         clk;
  logic         rst_n;
  logic         bus_en, bus_we;
  logic [2:0]   bus_addr;
  logic [W-1:0] bus_wdata, bus_rdata, hw_event;
  logic         bus_rvalid, irq_out;

  int n_chk, n_fail;
  bit done;

  logic [W-1:0] m_cause, m_mask, m_mode, m_rdata;

  irq_cause_regs #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .hw_event(hw_event), .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] read_val(input logic [2:0] a);
    case (a)
      3'd0: return m_mode;
      3'd1: return m_cause;
      3'd2: return m_cause & ~m_mask;
      3'd4: return m_mask;
      default: return '0;
    endcase
  endfunction

  function automatic logic [W-1:0] next_cause(input logic en, input logic we,
      input logic [2:0] a, input logic [W-1:0] d, input logic [W-1:0] hw);
    logic [W-1:0] clr, set;
    clr = '0;
    set = hw;
    if (en && we && (a == 3'd1 || a == 3'd2)) clr = d & ~m_mode;
    if (en && !we && a == 3'd1) clr = m_mode;
    if (en && !we && a == 3'd2) clr = m_mode & ~m_mask;
    if (en && we && a == 3'd3) set = set | d;
    return (m_cause & ~clr) | set;
  endfunction

  function automatic logic [W-1:0] next_mask(input logic en, input logic we,
      input logic [2:0] a, input logic [W-1:0] d);
    if (!(en && we)) return m_mask;
    case (a)
      3'd4: return d;
      3'd5: return m_mask | d;
      3'd6: return m_mask & ~d;
      default: return m_mask;
    endcase
  endfunction

  // One bus cycle; checks read data, rvalid and irq one cycle later.
  task automatic step(input string req, input logic en, input logic we,
      input logic [2:0] a, input logic [W-1:0] d, input logic [W-1:0] hw);
    logic [W-1:0] exp_rd;
    logic         is_rd;
    @(negedge clk);
    bus_en = en; bus_we = we; bus_addr = a; bus_wdata = d; hw_event = hw;
    is_rd = en && !we;
    exp_rd = is_rd ? read_val(a) : m_rdata;
    m_cause = next_cause(en, we, a, d, hw);
    m_mask  = next_mask(en, we, a, d);
    if (en && we && a == 3'd0) m_mode = d;
    m_rdata = exp_rd;
    @(posedge clk);
    #5;
    bus_en = 1'b0; hw_event = '0;
    if (is_rd) begin
      check({req, " R11 rvalid"}, {31'd0, bus_rvalid}, 32'd1);
      check({req, " rdata"}, bus_rdata, exp_rd);
    end
    check({req, " R10 irq"}, {31'd0, irq_out}, {31'd0, |(m_cause & ~m_mask)});
  endtask

  task automatic rd(input string req, input logic [2:0] a);
    step(req, 1'b1, 1'b0, a, '0, '0);
  endtask

  task automatic wr(input string req, input logic [2:0] a, input logic [W-1:0] d);
    step(req, 1'b1, 1'b1, a, d, '0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0;
    bus_wdata = '0; hw_event = '0;
    m_cause = '0; m_mask = '1; m_mode = '0; m_rdata = '0;
    repeat (3) @(posedge clk);
    #5;
    // R1 reset state
    check("R1 irq", {31'd0, irq_out}, 32'd0);
    check("R1 rdata", bus_rdata, '0);
    @(negedge clk); rst_n = 1'b1;
    rd("R1 mode", 3'd0);
    rd("R1 cause", 3'd1);
    rd("R1 mask", 3'd4);

    // R3 hw event sets cause, R6 masked view
    step("R3 hw", 1'b0, 1'b0, 3'd0, '0, 32'h0000_0011);
    rd("R3 cause", 3'd1);
    wr("R8 mask write", 3'd4, 32'hFFFF_FFF0);
    rd("R6 masked", 3'd2);
    // R4 W1C: write 0 no effect, write 1 clears
    wr("R4 w0", 3'd1, 32'h0000_0000);
    rd("R4 after w0", 3'd1);
    wr("R4 w1", 3'd2, 32'h0000_0001);
    rd("R4 after w1", 3'd1);
    // R3 set wins over clear in same cycle
    step("R3 race", 1'b1, 1'b1, 3'd1, 32'h0000_0010, 32'h0000_0010);
    rd("R3 race after", 3'd1);
    // R12 mode, R5 COR
    wr("R12 mode", 3'd0, 32'h0000_0F00);
    rd("R12 mode rd", 3'd0);
    wr("R7 cset", 3'd3, 32'h0000_0300);
    wr("R5 write ignored", 3'd1, 32'h0000_0300);
    rd("R5 pre-clear", 3'd1);
    rd("R5 cleared", 3'd1);
    wr("R7 cset2", 3'd3, 32'h0000_0C00);
    wr("R8 mset", 3'd5, 32'h0000_0800);
    rd("R5 masked read", 3'd2);
    rd("R5 masked keeps masked bit", 3'd1);
    wr("R8 mclr", 3'd6, 32'h0000_080F);
    rd("R8 mask rd", 3'd4);
    // R9 write-only reads zero, R2 reserved index
    rd("R9 cset", 3'd3);
    rd("R9 mset", 3'd5);
    rd("R9 mclr", 3'd6);
    wr("R2 rsvd write", 3'd7, 32'hFFFF_FFFF);
    rd("R2 rsvd read", 3'd7);
    rd("R2 cause after rsvd", 3'd1);
    rd("R2 mask after rsvd", 3'd4);

    // Random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic [2:0]   a;
      logic [W-1:0] d, hw;
      logic         en, we;
      en = ($urandom % 4) != 0;
      we = $urandom % 2;
      a  = 3'($urandom % 8);
      d  = $urandom & $urandom;
      hw = (($urandom % 4) == 0) ? (32'h1 << ($urandom % 32)) : '0;
      step("R3 R4 R5 R6 R7 R8 R9 R12 random", en, we, a, d, hw);
    end
    rd("R6 final masked", 3'd2);
    rd("R12 final mode", 3'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule